// File: doc/BRIEF.md
# Power Event Register Block with System Control Interrupt

This block gathers power-management events into a small set of host-visible registers and turns them into a single level-sensitive system control interrupt (SCI). A 16-bit fixed-event status register and a 16-bit fixed-event enable register sit at byte offsets 0 and 2. A byte-wide general-purpose event (GPE) status register and GPE enable register sit at offsets 4 and 5. Software reads the registers, clears status flags by writing ones, and chooses which events may raise the interrupt.

Two hardware sources feed the status registers. A one-cycle power-button strobe sets the power-button flag. A GPE raise strobe with a bit index sets one GPE flag, provided that bit is in the parameterised valid mask. A raise aimed at a bit outside the mask is refused and latches a sticky error output. The SCI is a registered level, recomputed every cycle from the status and enable contents.

Top module: `pwr_evt_regs`

## Requirements
- R1: After synchronous reset every status, enable and GPE register reads 0, `sci` is 0, `bus_err` is 0 and `gpe_raise_err` is 0.
- R2: Fixed status bit positions are timer 0x0001, bus master 0x0010, global 0x0020, power button 0x0100, sleep button 0x0200, RTC 0x0400 and wake 0x8000. A 2-byte write at offset 0 clears each bit of mask 0x8710 (wake, RTC, sleep button, power button, bus master) whose write-data bit is 1. Every other status bit is left as it was.
- R3: A 2-byte write at offset 2 stores only the RTC, power-button and global enable bits (data AND 0x0520). All other enable bits read back as 0.
- R4: At offsets 0 and 2 only size code 1 (two bytes) is accepted. Size codes are 0 = one byte, 1 = two bytes, 2 = four bytes and 3 = reserved. Any other size pulses `bus_err`, changes no register and returns read data 0.
- R5: A `pwrbtn_evt` strobe sets status bit 0x0100 on the next edge. The strobe wins over a write that clears that bit in the same cycle.
- R6: `sci` goes high when any of the timer, global, power-button, sleep-button or RTC bits is set in both status and enable. It goes high one cycle after the register change that causes this, and it stays low while the matching enable is 0.
- R7: At offsets 4 and 5 only size code 0 (one byte) is accepted. Any other size pulses `bus_err` and changes nothing.
- R8: GPE status at offset 4 is write-1-to-clear within the valid mask `GPE_VALID` (default 0x01). A write to GPE enable at offset 5 stores the data AND `GPE_VALID`.
- R9: A `gpe_raise` strobe whose `gpe_idx` is in `GPE_VALID` sets that GPE status bit. It wins over a same-cycle clear of that bit.
- R10: A `gpe_raise` strobe whose `gpe_idx` is outside `GPE_VALID` leaves the GPE status unchanged and sets `gpe_raise_err`, which then stays 1 until reset.
- R11: `sci` is also high when GPE status AND GPE enable is nonzero, one cycle after the register change. `sci` returns low one cycle after the last enabled source clears.
- R12: The mapped offsets are 0, 2, 4 and 5. An access to any other offset pulses `bus_err` for one cycle. Read data and `bus_err` are registered and are valid in the cycle after the access. `bus_err` is 0 after any cycle with no failing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | Registered error pulse for a refused access |
| pwrbtn_evt | input | 1 | Power-button event strobe |
| gpe_raise | input | 1 | GPE raise strobe |
| gpe_idx | input | IDX_W | Bit index for the GPE raise |
| gpe_raise_err | output | 1 | Sticky flag for a raise outside the valid mask |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
The hardest case to reach from the ports is a hardware set and a software clear of the same status bit landing in one clock. The bench reaches it by driving the power-button strobe, or the GPE raise, in the same cycle as the write-1-to-clear. It then reads back the status to confirm that the set won. The SCI lag is also hard to observe, because a status change and the interrupt are one register apart. To see it, enables are written after a status bit is already set. `sci` is then sampled only after the extra edge that the read access spends.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        SZ_B1  = 2'd0,
        SZ_B2  = 2'd1,
        SZ_B4  = 2'd2,
        SZ_RSV = 2'd3
    } acc_size_e;

    // fixed event bit positions (status and enable share them)
    localparam logic [DATA_W-1:0] EV_TMR = 16'h0001;
    localparam logic [DATA_W-1:0] EV_BM  = 16'h0010;
    localparam logic [DATA_W-1:0] EV_GBL = 16'h0020;
    localparam logic [DATA_W-1:0] EV_PB  = 16'h0100;
    localparam logic [DATA_W-1:0] EV_SB  = 16'h0200;
    localparam logic [DATA_W-1:0] EV_RTC = 16'h0400;
    localparam logic [DATA_W-1:0] EV_WAK = 16'h8000;

    localparam logic [DATA_W-1:0] STS_CLR_MASK = EV_WAK | EV_RTC | EV_SB | EV_PB | EV_BM;
    localparam logic [DATA_W-1:0] EN_WR_MASK   = EV_RTC | EV_PB | EV_GBL;
    localparam logic [DATA_W-1:0] SCI_SRC_MASK = EV_TMR | EV_GBL | EV_PB | EV_SB | EV_RTC;

    // register offsets
    localparam int OFS_FSTS = 0;
    localparam int OFS_FEN  = 2;
    localparam int OFS_GSTS = 4;
    localparam int OFS_GEN  = 5;

    typedef struct packed {
        logic fsts;
        logic fen;
        logic gsts;
        logic gen;
    } reg_sel_t;

    typedef struct packed {
        reg_sel_t sel;
        logic     access;
        logic     bad;
    } dec_res_t;

    function automatic logic size_ok(acc_size_e sz, logic wide);
        return wide ? (sz == SZ_B2) : (sz == SZ_B1);
    endfunction

    function automatic logic fixed_sci_need(logic [DATA_W-1:0] sts, logic [DATA_W-1:0] en);
        return |(sts & en & SCI_SRC_MASK);
    endfunction

endpackage

// File: rtl/pwr_evt_decode.sv
module pwr_evt_decode
    import pwr_evt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  logic              rd,
    input  logic              wr,
    output dec_res_t          res
);
    logic hit_fsts, hit_fen, hit_gsts, hit_gen, mapped, fit;

    always_comb begin
        hit_fsts = (addr == ADDR_W'(OFS_FSTS));
        hit_fen  = (addr == ADDR_W'(OFS_FEN));
        hit_gsts = (addr == ADDR_W'(OFS_GSTS));
        hit_gen  = (addr == ADDR_W'(OFS_GEN));
        mapped   = hit_fsts | hit_fen | hit_gsts | hit_gen;
        fit      = ((hit_fsts | hit_fen) & size_ok(size, 1'b1)) |
                   ((hit_gsts | hit_gen) & size_ok(size, 1'b0));

        res.access   = rd | wr;
        res.bad      = res.access & ~(mapped & fit);
        res.sel.fsts = res.access & fit & hit_fsts;
        res.sel.fen  = res.access & fit & hit_fen;
        res.sel.gsts = res.access & fit & hit_gsts;
        res.sel.gen  = res.access & fit & hit_gen;
    end
endmodule

// File: rtl/pwr_evt_fixed.sv
module pwr_evt_fixed
    import pwr_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sts,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pb_evt,
    output logic [DATA_W-1:0] sts_o,
    output logic [DATA_W-1:0] en_o
);
    logic [DATA_W-1:0] sts_q, en_q, clr_vec, set_vec;

    always_comb begin
        clr_vec = wr_sts ? (wdata & STS_CLR_MASK) : '0;
        set_vec = pb_evt ? EV_PB : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_vec) | set_vec;
            if (wr_en)
                en_q <= wdata & EN_WR_MASK;
        end
    end

    assign sts_o = sts_q;
    assign en_o  = en_q;

    // R5: the strobe always leaves the power-button flag set
    a_r5_pb_sets: assert property (@(posedge clk) disable iff (rst)
        pb_evt |=> ((sts_q & EV_PB) != '0));

    // R2: without a hardware event no status bit can rise
    a_r2_no_sw_set: assert property (@(posedge clk) disable iff (rst)
        !pb_evt |=> ((sts_q & ~$past(sts_q)) == '0));

    // R3: enable only moves on a write
    a_r3_en_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(en_q));
endmodule

// File: rtl/pwr_evt_gpe.sv
module pwr_evt_gpe #(
    parameter int              GPE_W     = 8,
    parameter logic [GPE_W-1:0] GPE_VALID = 1,
    parameter int              IDX_W     = (GPE_W > 1) ? $clog2(GPE_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic [GPE_W-1:0] wdata,
    input  logic             raise,
    input  logic [IDX_W-1:0] raise_idx,
    output logic [GPE_W-1:0] sts_o,
    output logic [GPE_W-1:0] en_o,
    output logic             raise_err_o
);
    logic [GPE_W-1:0] sts_q, en_q;
    logic             err_q;
    logic             legal;

    assign legal = raise & GPE_VALID[raise_idx];

    for (genvar i = 0; i < GPE_W; i++) begin : g_bit
        logic set_b, clr_b;
        assign set_b = legal & (raise_idx == IDX_W'(i));
        assign clr_b = wr_sts & wdata[i] & GPE_VALID[i];
        always_ff @(posedge clk) begin
            if (rst)
                sts_q[i] <= 1'b0;
            else
                sts_q[i] <= (sts_q[i] & ~clr_b) | set_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            err_q <= 1'b0;
        end else begin
            if (wr_en)
                en_q <= wdata & GPE_VALID;
            if (raise & ~GPE_VALID[raise_idx])
                err_q <= 1'b1;
        end
    end

    assign sts_o       = sts_q;
    assign en_o        = en_q;
    assign raise_err_o = err_q;

    // R9: a legal raise lands in the named bit
    a_r9_raise_sets: assert property (@(posedge clk) disable iff (rst)
        legal |=> sts_q[$past(raise_idx)]);

    // R10: the error flag never falls once set
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R10: an illegal raise alone leaves status untouched
    a_r10_no_set: assert property (@(posedge clk) disable iff (rst)
        (raise && !legal && !wr_sts) |=> $stable(sts_q));
endmodule

// File: rtl/pwr_evt_sci.sv
module pwr_evt_sci
    import pwr_evt_pkg::*;
#(
    parameter int GPE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] fix_sts,
    input  logic [DATA_W-1:0] fix_en,
    input  logic [GPE_W-1:0]  gpe_sts,
    input  logic [GPE_W-1:0]  gpe_en,
    output logic              sci_o
);
    logic need, sci_q;

    assign need = fixed_sci_need(fix_sts, fix_en) | (|(gpe_sts & gpe_en));

    always_ff @(posedge clk) begin
        if (rst)
            sci_q <= 1'b0;
        else
            sci_q <= need;
    end

    assign sci_o = sci_q;

    // R11: once every enabled source is quiet, the level drops next cycle
    a_r11_drop: assert property (@(posedge clk) disable iff (rst)
        ((fix_sts & fix_en & SCI_SRC_MASK) == '0 && (gpe_sts & gpe_en) == '0) |=> !sci_q);
endmodule

// File: rtl/pwr_evt_regs.sv
module pwr_evt_regs
    import pwr_evt_pkg::*;
#(
    parameter int               ADDR_W    = 3,
    parameter int               GPE_W     = 8,
    parameter logic [GPE_W-1:0] GPE_VALID = 1,
    parameter int               IDX_W     = (GPE_W > 1) ? $clog2(GPE_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              bus_err,
    input  logic              pwrbtn_evt,
    input  logic              gpe_raise,
    input  logic [IDX_W-1:0]  gpe_idx,
    output logic              gpe_raise_err,
    output logic              sci
);
    localparam int PAD_W = DATA_W - GPE_W;

    dec_res_t          dec;
    logic [DATA_W-1:0] fix_sts, fix_en;
    logic [GPE_W-1:0]  gpe_sts, gpe_en;
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic              err_q;

    pwr_evt_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .size (acc_size_e'(bus_size)),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .res  (dec)
    );

    pwr_evt_fixed u_fix (
        .clk    (clk),
        .rst    (rst),
        .wr_sts (bus_wr & dec.sel.fsts),
        .wr_en  (bus_wr & dec.sel.fen),
        .wdata  (bus_wdata),
        .pb_evt (pwrbtn_evt),
        .sts_o  (fix_sts),
        .en_o   (fix_en)
    );

    pwr_evt_gpe #(.GPE_W(GPE_W), .GPE_VALID(GPE_VALID), .IDX_W(IDX_W)) u_gpe (
        .clk         (clk),
        .rst         (rst),
        .wr_sts      (bus_wr & dec.sel.gsts),
        .wr_en       (bus_wr & dec.sel.gen),
        .wdata       (bus_wdata[GPE_W-1:0]),
        .raise       (gpe_raise),
        .raise_idx   (gpe_idx),
        .sts_o       (gpe_sts),
        .en_o        (gpe_en),
        .raise_err_o (gpe_raise_err)
    );

    pwr_evt_sci #(.GPE_W(GPE_W)) u_sci (
        .clk     (clk),
        .rst     (rst),
        .fix_sts (fix_sts),
        .fix_en  (fix_en),
        .gpe_sts (gpe_sts),
        .gpe_en  (gpe_en),
        .sci_o   (sci)
    );

    always_comb begin
        unique case (1'b1)
            dec.sel.fsts: rd_mux = fix_sts;
            dec.sel.fen:  rd_mux = fix_en;
            dec.sel.gsts: rd_mux = {{PAD_W{1'b0}}, gpe_sts};
            dec.sel.gen:  rd_mux = {{PAD_W{1'b0}}, gpe_en};
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= dec.bad;
            if (bus_rd)
                rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;

    // R4, R7: a refused access leaves every enable and status register alone
    a_r4_refused_no_change: assert property (@(posedge clk) disable iff (rst)
        (dec.bad && !pwrbtn_evt && !gpe_raise) |=>
            ($stable(fix_sts) && $stable(fix_en) && $stable(gpe_sts) && $stable(gpe_en)));

    // R12: the error pulse follows a refused access
    a_r12_err_follows: assert property (@(posedge clk) disable iff (rst)
        dec.bad |=> bus_err);

    // R12: no access, no error
    a_r12_err_idle: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |=> !bus_err);

    // R6: the interrupt needs some enable set in the previous cycle
    a_r6_sci_needs_en: assert property (@(posedge clk) disable iff (rst)
        sci |-> $past((|fix_en) || (|gpe_en)));
endmodule

// File: tb/pwr_evt_regs_bench.sv
`timescale 1ns/1ps
module pwr_evt_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic        pwrbtn_evt = 1'b0;
    logic        gpe_raise = 1'b0;
    logic [2:0]  gpe_idx = '0;
    logic        gpe_raise_err;
    logic        sci;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [1:0] S1 = 2'd0, S2 = 2'd1, S4 = 2'd2;

    always #2 clk = ~clk;

    pwr_evt_regs u_pwr_evt_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .pwrbtn_evt(pwrbtn_evt),
        .gpe_raise(gpe_raise), .gpe_idx(gpe_idx),
        .gpe_raise_err(gpe_raise_err), .sci(sci)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic acc(input logic [2:0] a, input logic [1:0] sz, input logic w,
                       input logic [15:0] d, output logic [15:0] rv, output logic e);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wr = w; bus_rd = !w; bus_wdata = d;
        @(negedge clk);
        rv = bus_rdata; e = bus_err;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] sz, input logic [15:0] d, output logic e);
        logic [15:0] dummy;
        acc(a, sz, 1'b1, d, dummy, e);
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] sz, output logic [15:0] v, output logic e);
        acc(a, sz, 1'b0, 16'h0, v, e);
    endtask

    task automatic pulse_pb();
        @(negedge clk); pwrbtn_evt = 1'b1;
        @(negedge clk); pwrbtn_evt = 1'b0;
    endtask

    task automatic raise(input logic [2:0] idx);
        @(negedge clk); gpe_raise = 1'b1; gpe_idx = idx;
        @(negedge clk); gpe_raise = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v; logic e;
        chk("R1 sci", sci, 0);
        chk("R1 raise_err", gpe_raise_err, 0);
        rd(3'd0, S2, v, e); chk("R1 fixed status", v, 0); chk("R1 err", e, 0);
        rd(3'd2, S2, v, e); chk("R1 fixed enable", v, 0);
        rd(3'd4, S1, v, e); chk("R1 gpe status", v, 0);
        rd(3'd5, S1, v, e); chk("R1 gpe enable", v, 0);
    endtask

    task automatic t_enable_mask();
        logic [15:0] v; logic e;
        wr(3'd2, S2, 16'hFFFF, e); chk("R3 write err", e, 0);
        rd(3'd2, S2, v, e); chk("R3 masked enable", v, 16'h0520);
        wr(3'd2, S2, 16'hFADF, e);
        rd(3'd2, S2, v, e); chk("R3 no writable bits", v, 16'h0000);
    endtask

    task automatic t_pwrbtn_sci();
        logic [15:0] v; logic e;
        pulse_pb();
        rd(3'd0, S2, v, e); chk("R5 pb status", v, 16'h0100);
        tick(1); chk("R6 sci off while disabled", sci, 0);
        wr(3'd2, S2, 16'h0100, e);
        chk("R6 sci lags enable by a cycle", sci, 0);
        tick(1); chk("R6 sci on", sci, 1);
        wr(3'd0, S2, 16'hFEFF, e);
        rd(3'd0, S2, v, e); chk("R2 other bits do not clear pb", v, 16'h0100);
        chk("R6 sci still on", sci, 1);
        wr(3'd0, S2, 16'h0100, e);
        rd(3'd0, S2, v, e); chk("R2 pb cleared", v, 16'h0000);
        chk("R11 sci drops after clear", sci, 0);
    endtask

    task automatic t_collision_pb();
        logic [15:0] v; logic e;
        pulse_pb();
        @(negedge clk);
        bus_addr = 3'd0; bus_size = S2; bus_wr = 1'b1; bus_wdata = 16'h0100; pwrbtn_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; pwrbtn_evt = 1'b0;
        rd(3'd0, S2, v, e); chk("R5 set wins over clear", v, 16'h0100);
        wr(3'd0, S2, 16'hFFFF, e);
        rd(3'd0, S2, v, e); chk("R2 full clear", v, 16'h0000);
        wr(3'd2, S2, 16'h0000, e);
    endtask

    task automatic t_bad_size();
        logic [15:0] v; logic e;
        wr(3'd2, S1, 16'hFFFF, e); chk("R4 byte write err", e, 1);
        wr(3'd2, S4, 16'hFFFF, e); chk("R4 dword write err", e, 1);
        tick(1); chk("R12 err clears when idle", bus_err, 0);
        rd(3'd2, S2, v, e); chk("R4 enable unchanged", v, 16'h0000);
        pulse_pb();
        wr(3'd0, S1, 16'hFFFF, e); chk("R4 byte status write err", e, 1);
        rd(3'd0, S1, v, e); chk("R4 bad read data zero", v, 16'h0000); chk("R4 bad read err", e, 1);
        rd(3'd0, S2, v, e); chk("R4 status kept", v, 16'h0100);
        wr(3'd0, S2, 16'h0100, e);
    endtask

    task automatic t_gpe();
        logic [15:0] v; logic e;
        wr(3'd5, S2, 16'h00FF, e); chk("R7 wide gpe write err", e, 1);
        rd(3'd5, S1, v, e); chk("R7 gpe enable unchanged", v, 0);
        wr(3'd5, S1, 16'h00FF, e); chk("R7 byte write ok", e, 0);
        rd(3'd5, S1, v, e); chk("R8 gpe enable masked", v, 16'h0001);
        raise(3'd0);
        rd(3'd4, S1, v, e); chk("R9 gpe bit set", v, 16'h0001);
        chk("R11 sci from gpe", sci, 1);
        wr(3'd4, S1, 16'h00FE, e);
        rd(3'd4, S1, v, e); chk("R8 w1c ignores zero bit", v, 16'h0001);
        wr(3'd4, S1, 16'h0001, e);
        rd(3'd4, S1, v, e); chk("R8 w1c clears", v, 16'h0000);
        chk("R11 sci drops", sci, 0);
        @(negedge clk);
        bus_addr = 3'd4; bus_size = S1; bus_wr = 1'b1; bus_wdata = 16'h0001;
        gpe_raise = 1'b1; gpe_idx = 3'd0;
        @(negedge clk);
        bus_wr = 1'b0; gpe_raise = 1'b0;
        rd(3'd4, S1, v, e); chk("R9 raise wins over clear", v, 16'h0001);
        wr(3'd4, S1, 16'h0001, e);
    endtask

    task automatic t_gpe_illegal();
        logic [15:0] v; logic e;
        chk("R10 err low before", gpe_raise_err, 0);
        raise(3'd3);
        chk("R10 err set", gpe_raise_err, 1);
        rd(3'd4, S1, v, e); chk("R10 status unchanged", v, 16'h0000);
        tick(3); chk("R10 err sticky", gpe_raise_err, 1);
    endtask

    task automatic t_unmapped();
        logic [15:0] v; logic e;
        wr(3'd1, S2, 16'hFFFF, e); chk("R12 unmapped write err", e, 1);
        rd(3'd7, S1, v, e); chk("R12 unmapped read err", e, 1);
        rd(3'd3, S2, v, e); chk("R12 offset 3 err", e, 1);
        tick(1); chk("R12 err one cycle", bus_err, 0);
    endtask

    initial begin : watchdog
        int n = 0;
        while (!done && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_enable_mask();
        t_pwrbtn_sci();
        t_collision_pb();
        t_bad_size();
        t_gpe();
        t_unmapped();
        t_gpe_illegal();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule